// File: doc/BRIEF.md
# Glitch-Free Gated Clock Divider

This block takes one free-running input clock and derives a slower clock from it. The ratio is one of four powers of two: 1, 2, 4 or 8, chosen by a 2-bit select. A run enable stops and restarts the derived clock. Both control inputs may come from any domain. Each passes through a two-flop synchronizer before it has any effect. Neither control is applied in the middle of an output period, so the derived clock never shows a short high or low phase. This holds when the enable changes, when the ratio changes, and when both change together.

Next to the derived clock, the block drives a strobe that is one input-clock cycle wide. The strobe marks the start of every output period while the output runs. Logic that stays on the fast clock can use this strobe as a clock enable, so that logic never has to be clocked by the derived clock.

For ratios above one, the derived clock comes straight from a register, which gives an exact half-and-half duty cycle. For the undivided ratio, a gate signal passes through a latch that is open while the input clock is low. The latch output is then ANDed with the input clock.

Top module: `gated_clk_div`

## Requirements
- R1: Select code 1 divides by 2, code 2 by 4 and code 3 by 8. For these ratios `clk_o` rises on a rising edge of `clk_i`, stays high for exactly half the period, and then stays low for the other half.
- R2: Select code 0 divides by 1. While the output runs, `clk_o` follows `clk_i`, with every high phase a full half cycle of `clk_i`.
- R3: A new select value is applied only when the current output period has finished. A period that has started always completes at the ratio it started with.
- R4: The enable is likewise applied only at a period boundary. A stopped `clk_o` rests low. Neither starting nor stopping produces a high or low phase shorter than half a `clk_i` cycle.
- R5: `en_i` and `sel_i` each pass through a two-flop synchronizer. With ratio 1 selected and the output stopped, an enable driven high before rising edge k of `clk_i` produces the first high phase of `clk_o` in the cycle that begins at edge k+2.
- R6: `stb_o` is high for exactly one `clk_i` cycle at the start of each output period, which is the cycle in which `clk_o` rises. It is high only while the output runs, so at ratio 4 it is high 16 times in any 64-cycle window.
- R7: While `rst_n_i` is low at a rising edge of `clk_i`, the block does the following: clears the divide counter, stops the output, selects divide by 1, and drives `clk_o` and `stb_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_n_i | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable for the derived clock; asynchronous to clk_i |
| sel_i | input | 2 | Ratio select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| clk_o | output | 1 | Gated, divided clock |
| stb_o | output | 1 | One-cycle strobe marking each rising edge of clk_o |

## Verification
The bench uses the default synchronizer depth of two and the two-bit select. With these values, all four ratios are reachable, including the largest, which needs the full three-bit counter. The bench changes the ratio at many offsets inside a period. It switches between the latched divide-by-1 path and the registered path in both directions. It also toggles the enable with pulses as short as one cycle. These cases cover boundary deferral, synchronizer latency and the absence of runt pulses on the output.

// File: rtl/gclk_pkg.sv
// Package: shared widths and types for the gated clock divider.
// Assumes ratios are powers of two selected by a SEL_W-bit code.
package gclk_pkg;
    localparam int SEL_W = 2;
    localparam int CNT_W = (1 << SEL_W) - 1;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
        sel_t sel;
        logic run;
    } div_state_t;
endpackage

// File: rtl/gcd_sync.sv
// Module: multi-flop synchronizer for a slow control bus.
// Assumes each bus bit is quasi-static or gray-safe across the capture window.
module gcd_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Purpose: shift the input through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gcd_core.sv
// Module: divide counter, ratio and run state, registered clock and strobe.
// Assumes synchronized controls; applies them only at the period wrap.
// Also drives the next-cycle gate for the divide-by-1 latch path.
module gcd_core
    import gclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_s_i,
    input  sel_t sel_s_i,
    output logic div_o,
    output logic stb_o,
    output logic gate_o
);
    div_state_t st_q, st_n;
    logic       wrap, div_n, stb_n;

    // Period length in input cycles for a given select code.
    function automatic logic [CNT_W:0] span(sel_t s);
        return (CNT_W+1)'(1) << s;
    endfunction

    // Purpose: next-state, boundary detection and next outputs.
    always_comb begin
        wrap = ({1'b0, st_q.cnt} == span(st_q.sel) - 1'b1);
        st_n = st_q;
        if (wrap) begin
            st_n.cnt = '0;
            st_n.sel = sel_s_i;
            st_n.run = en_s_i;
        end else begin
            st_n.cnt = st_q.cnt + 1'b1;
        end
        div_n  = st_n.run && (st_n.sel != '0) &&
                 ({1'b0, st_n.cnt} < (span(st_n.sel) >> 1));
        stb_n  = st_n.run && (st_n.cnt == '0);
        gate_o = rst_n_i && st_n.run && (st_n.sel == '0);
    end

    // Purpose: register state and glitch-free outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            st_q  <= '0;
            div_o <= 1'b0;
            stb_o <= 1'b0;
        end else begin
            st_q  <= st_n;
            div_o <= div_n;
            stb_o <= stb_n;
        end
    end

    // R1: the last cycle of a divided period is always low
    a_r1_last_low: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wrap && st_q.sel != '0) |-> !div_o);
    // R3: ratio holds until the period wraps
    a_r3_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wrap |=> $stable(st_q.sel));
    // R4: run state holds until the period wraps
    a_r4_run_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !wrap |=> $stable(st_q.run));
    // R5: run only ever takes the synchronized enable value
    a_r5_run_src: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(st_q.run) |-> (st_q.run == $past(en_s_i)));
    // R6: every rise of the divided clock carries a strobe
    a_r6_stb_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        $rose(div_o) |-> stb_o);
    // R7: reset clears outputs and state
    a_r7_reset: assert property (@(posedge clk_i)
        !rst_n_i |=> (!div_o && !stb_o && st_q == '0));
endmodule

// File: rtl/gcd_gate.sv
// Module: output stage; latch-based gate for divide by 1 merged with the
// registered divided clock. Assumes gate_i settles during the low phase.
module gcd_gate (
    input  logic clk_i,
    input  logic gate_i,
    input  logic div_i,
    output logic clk_o
);
    logic lat_q;

    // Purpose: hold the gate steady through the high phase of clk_i.
    always_latch begin
        if (!clk_i) lat_q <= gate_i;
    end

    assign clk_o = (clk_i & lat_q) | div_i;
endmodule

// File: rtl/gated_clk_div.sv
// Module: top of the glitch-free gated clock divider.
// Assumes clk_i free-running; en_i and sel_i may be asynchronous.
module gated_clk_div
    import gclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             clk_o,
    output logic             stb_o
);
    logic en_s, div_w, gate_w;
    sel_t sel_s;

    gcd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_en_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(en_i), .q_o(en_s));

    gcd_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_sel_sync (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .d_i(sel_i), .q_o(sel_s));

    gcd_core u_core (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .en_s_i(en_s), .sel_s_i(sel_s),
        .div_o(div_w), .stb_o(stb_o), .gate_o(gate_w));

    gcd_gate u_gate (
        .clk_i(clk_i), .gate_i(gate_w), .div_i(div_w), .clk_o(clk_o));
endmodule

// File: tb/gated_clk_div_test.sv
`timescale 1ns/1ps
module gated_clk_div_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       clk_o, stb_o;

    int    checks = 0, errors = 0;
    string tag = "R7";
    bit    chk_on = 0, done = 0;

    // Reference model state
    int  en_pipe[$] = '{0, 0};
    int  sel_pipe[$] = '{0, 0};
    int  m_pos = 0, m_div = 1, m_run = 0;
    int  rises = 0;
    real t_rise = -1.0, t_fall = -1.0;

    gated_clk_div uut (.clk_i(clk), .rst_n_i(rst_n), .en_i(en), .sel_i(sel),
                       .clk_o(clk_o), .stb_o(stb_o));

    always #2.5 clk = ~clk;

    task automatic chk(input string t, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
        end
    endtask

    // Behavioural model: queues stand in for the synchronizers
    always @(posedge clk) begin
        int es, ss;
        if (!rst_n) begin
            en_pipe = '{0, 0}; sel_pipe = '{0, 0};
            m_pos = 0; m_div = 1; m_run = 0;
        end else begin
            es = en_pipe.pop_front();  en_pipe.push_back(int'(en));
            ss = sel_pipe.pop_front(); sel_pipe.push_back(int'(sel));
            if (m_pos == m_div - 1) begin
                m_pos = 0; m_div = 1 << ss; m_run = es;
            end else m_pos++;
        end
    end

    // Compare in the high half of each clk cycle
    always @(posedge clk) begin
        #1;
        if (chk_on) begin
            chk({tag, " clk_o high"}, int'(clk_o),
                int'(m_run == 1 && (m_div == 1 || m_pos < m_div / 2)));
            chk({tag, " stb_o"}, int'(stb_o), int'(m_run == 1 && m_pos == 0));
        end
    end

    // Compare in the low half of each clk cycle
    always @(negedge clk) begin
        #1;
        if (chk_on)
            chk({tag, " clk_o low"}, int'(clk_o),
                int'(m_run == 1 && m_div > 1 && m_pos < m_div / 2));
    end

    // R4: no runt phase on the output clock
    always @(posedge clk_o) begin
        rises++;
        if (chk_on && t_fall >= 0.0)
            chk("R4 low phase >= half cycle", int'($realtime - t_fall >= 2.49), 1);
        t_rise = $realtime;
    end
    always @(negedge clk_o) begin
        if (chk_on && t_rise >= 0.0)
            chk("R4 high phase >= half cycle", int'($realtime - t_rise >= 2.49), 1);
        t_fall = $realtime;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        real t0;
        int  r0, sc;
        // R7: reset state
        cyc(2); chk_on = 1; cyc(2);
        #1; chk("R7 clk_o in reset", int'(clk_o), 0);
        chk("R7 stb_o in reset", int'(stb_o), 0);
        rst_n = 1'b1;

        // R2: divide by 1
        tag = "R2"; en = 1'b1; sel = 2'd0; cyc(20);

        // R1: each divided ratio, steady
        tag = "R1"; sel = 2'd1; cyc(30);
        sel = 2'd2; cyc(40);
        sel = 2'd3; cyc(60);
        @(posedge clk_o); t0 = $realtime; @(posedge clk_o);
        chk("R1 divide-by-8 period ns", int'($realtime - t0), 40);
        @(negedge clk_o);
        chk("R1 divide-by-8 high ns", int'($realtime - t0 - 40.0), 20);

        // R3: ratio changes at many offsets
        tag = "R3";
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); sel = 2'((i * 3 + 1) % 4);
            cyc(3 + i % 7);
        end

        // R4: enable toggling incl. one-cycle pulses
        tag = "R4";
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); en = ~en; sel = 2'((i / 5) % 4);
            cyc(1 + (i * 5) % 11);
        end

        // R5: latency of the enable at divide by 1
        tag = "R5"; en = 1'b0; sel = 2'd0; cyc(20);
        @(negedge clk); en = 1'b1;
        @(posedge clk); #1; chk("R5 edge k still low", int'(clk_o), 0);
        @(posedge clk); #1; chk("R5 edge k+1 still low", int'(clk_o), 0);
        @(posedge clk); #1; chk("R5 edge k+2 high", int'(clk_o), 1);

        // R6: strobe and rise count over a 64-cycle window at ratio 4
        tag = "R6"; sel = 2'd2; cyc(24);
        r0 = rises; sc = 0;
        for (int i = 0; i < 64; i++) begin
            @(posedge clk); #1; if (stb_o) sc++;
        end
        chk("R6 strobes in 64 cycles", sc, 16);
        chk("R6 rises in 64 cycles", rises - r0, 16);
        tag = "R6"; en = 1'b0; cyc(20);
        sc = 0;
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1; if (stb_o) sc++;
        end
        chk("R6 no strobe while stopped", sc, 0);

        // R7: reset in the middle of a running divide-by-8
        tag = "R7"; en = 1'b1; sel = 2'd3; cyc(15);
        @(negedge clk); rst_n = 1'b0; cyc(3);
        #1; chk("R7 clk_o after mid-run reset", int'(clk_o), 0);
        chk("R7 stb_o after mid-run reset", int'(stb_o), 0);
        en = 1'b0; @(negedge clk); rst_n = 1'b1;
        tag = "R2"; en = 1'b1; sel = 2'd0; cyc(12);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule